// File: doc/BRIEF.md
# Mesh Router Output-Port Selector

This block decides, for one router of a two-dimensional mesh, which output port a packet's head flit should leave through. It compares the router's own column and row with the destination column and row carried by the head flit. From that comparison it works out which directions bring the packet closer. A routing-mode input then restricts those directions to the ones that the chosen turn discipline allows. The output is a one-hot port code covering East, West, North, South and Local.

Three disciplines are available. The first is fixed dimension order, which finishes the column before the row and keeps packets in order. The second allows adaptive choice except that westward travel must come first. The third allows adaptive choice except that northward travel must come last. Each discipline forbids just enough turns to break every cycle, so the network cannot deadlock. Because every move shortens the remaining distance, it cannot livelock either. In the two adaptive disciplines, per-direction congestion flags steer the choice towards a free neighbour.

The decision is registered. A head-flit strobe produces a valid port code on the following clock cycle.

Top module: `mesh_route_unit`

## Requirements
- R1: While reset is active, and directly after it, `out_valid` is 0 and `out_port` is 5'b00000.
- R2: `out_valid` equals `in_valid` one cycle later. `out_port` takes a new value only in a cycle where `in_valid` was 1 and otherwise keeps its last value.
- R3: When `dst_x == cur_x` and `dst_y == cur_y`, the port is Local (`out_port` bit 0) in every mode.
- R4: Routing is minimal. East (bit 1) is chosen only if `dst_x > cur_x`, West (bit 2) only if `dst_x < cur_x`, North (bit 3) only if `dst_y > cur_y`, and South (bit 4) only if `dst_y < cur_y`. North is increasing Y and East is increasing X.
- R5: In fixed dimension-order mode (`mode` 0, and also `mode` 3), the port is East or West while the columns differ. North or South is used only once the columns match.
- R6: In west-first mode (`mode` 1), if the destination lies to the west, the port is West, whatever the congestion flags say.
- R7: In west-first mode, if no westward travel is needed, the port is chosen adaptively among the needed East, North and South directions.
- R8: In north-last mode (`mode` 2), North is chosen only when no East, West or South travel is still needed.
- R9: In north-last mode, when North is excluded, the port is chosen adaptively among the needed East, West and South directions.
- R10: For an adaptive choice, the congestion flags are `cong` bit 0 East, bit 1 West, bit 2 North and bit 3 South. A permitted direction whose flag is clear is preferred. If the permitted directions are all congested, or none of them is, the fixed order East, West, North, South decides.
- R11: In fixed dimension-order mode, the congestion flags have no effect on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head flit present; request a routing decision |
| mode | input | 2 | 0 dimension order, 1 west-first, 2 north-last, 3 dimension order |
| cur_x | input | COORD_W | This router's column |
| cur_y | input | COORD_W | This router's row |
| dst_x | input | COORD_W | Destination column from the head flit |
| dst_y | input | COORD_W | Destination row from the head flit |
| cong | input | 4 | Congestion flags: bit0 East, bit1 West, bit2 North, bit3 South |
| out_valid | output | 1 | Routing decision valid |
| out_port | output | 5 | One-hot port: bit0 Local, bit1 East, bit2 West, bit3 North, bit4 South |

## Verification
Every result of this block is due exactly one rising edge after the head-flit strobe, since only one register stage lies between the inputs and the ports. The bench applies the strobe and its coordinates on a falling edge and drops the strobe on the next falling edge. It reads `out_valid` and `out_port` there, half a period after the registering edge. One further falling edge later, with the strobe low, it reads both ports again to confirm that the valid flag has cleared and the port code is held.

// File: rtl/route_pkg.sv
package route_pkg;
    localparam int NUM_PORTS = 5;
    localparam int NUM_DIRS  = 4;

    typedef enum logic [1:0] {
        MODE_XY     = 2'd0,
        MODE_WF     = 2'd1,
        MODE_NL     = 2'd2,
        MODE_XY_ALT = 2'd3
    } route_mode_e;

    // bit order east(0), west(1), north(2), south(3) is also the fallback priority
    typedef struct packed {
        logic south;
        logic north;
        logic west;
        logic east;
    } dir_set_t;

    typedef struct packed {
        logic                 vld;
        logic [NUM_PORTS-1:0] port;
    } route_state_t;
endpackage

// File: rtl/route_dir_cmp.sv
module route_dir_cmp
    import route_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output dir_set_t           need,
    output logic               arrived
);
    always_comb begin
        need.east  = dst_x > cur_x;
        need.west  = dst_x < cur_x;
        need.north = dst_y > cur_y;
        need.south = dst_y < cur_y;
        arrived    = (dst_x == cur_x) && (dst_y == cur_y);
    end
endmodule

// File: rtl/route_turn_filter.sv
module route_turn_filter
    import route_pkg::*;
(
    input  route_mode_e mode,
    input  dir_set_t    need,
    output dir_set_t    allowed
);
    always_comb begin
        allowed = need;
        case (mode)
            MODE_WF: begin
                // westward leg must be finished before anything else
                if (need.west) begin
                    allowed       = '0;
                    allowed.west  = 1'b1;
                end
            end
            MODE_NL: begin
                // northward leg may only be the last one
                if (need.east || need.west || need.south) begin
                    allowed.north = 1'b0;
                end
            end
            default: begin
                // dimension order: finish X before touching Y
                if (need.east || need.west) begin
                    allowed.north = 1'b0;
                    allowed.south = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/route_pick.sv
module route_pick
    import route_pkg::*;
(
    input  dir_set_t              allowed,
    input  logic [NUM_DIRS-1:0]   cong,
    output logic [NUM_DIRS-1:0]   choice
);
    logic [NUM_DIRS-1:0] free_dirs;
    logic [NUM_DIRS-1:0] pool;
    logic                found;

    always_comb begin
        free_dirs = allowed & ~cong;
        pool      = (free_dirs != '0) ? free_dirs : allowed;
        choice    = '0;
        found     = 1'b0;
        for (int i = 0; i < NUM_DIRS; i++) begin
            if (pool[i] && !found) begin
                choice[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import route_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [COORD_W-1:0]   cur_x,
    input  logic [COORD_W-1:0]   cur_y,
    input  logic [COORD_W-1:0]   dst_x,
    input  logic [COORD_W-1:0]   dst_y,
    input  logic [NUM_DIRS-1:0]  cong,
    output logic                 out_valid,
    output logic [NUM_PORTS-1:0] out_port
);
    localparam logic [NUM_PORTS-1:0] PORT_LOCAL = NUM_PORTS'(1);

    dir_set_t            need;
    dir_set_t            allowed;
    logic                arrived;
    logic [NUM_DIRS-1:0] choice;
    route_state_t        state_d, state_q;

    route_dir_cmp #(.COORD_W(COORD_W)) u_cmp (
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .dst_x   (dst_x),
        .dst_y   (dst_y),
        .need    (need),
        .arrived (arrived)
    );

    route_turn_filter u_filter (
        .mode    (route_mode_e'(mode)),
        .need    (need),
        .allowed (allowed)
    );

    route_pick u_pick (
        .allowed (allowed),
        .cong    (cong),
        .choice  (choice)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.port = arrived ? PORT_LOCAL : {choice, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_port  = state_q.port;

    // R1 / R2: valid timing and port shape
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_port)));
    assert_port_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_port) == 1));
    // R3: arrival goes to the local port
    assert_arrive_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_x == cur_x && dst_y == cur_y) |=> (out_port == PORT_LOCAL));
    // R4: each direction must shorten the distance
    assert_minimal_east_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_port[1] || $past(dst_x > cur_x)));
    assert_minimal_west_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_port[2] || $past(dst_x < cur_x)));
    assert_minimal_north_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_port[3] || $past(dst_y > cur_y)));
    assert_minimal_south_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_port[4] || $past(dst_y < cur_y)));
    // R5: dimension order finishes X first
    assert_xy_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 2'd0 || mode == 2'd3) && dst_x != cur_x)
            |=> (out_port[1] || out_port[2]));
    // R6: west-first forces west
    assert_wf_west_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1 && dst_x < cur_x) |=> out_port[2]);
    // R8: north-last keeps north for last
    assert_nl_north_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2 && (dst_x != cur_x || dst_y < cur_y)) |=> !out_port[3]);
endmodule

// File: tb/mesh_route_unit_tb_top.sv
module mesh_route_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [1:0] mode;
    logic [2:0] cur_x, cur_y, dst_x, dst_y;
    logic [3:0] cong;
    logic       out_valid;
    logic [4:0] out_port;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [4:0] L = 5'b00001, E = 5'b00010, W = 5'b00100,
                           N = 5'b01000, S = 5'b10000;

    always #10 clk = ~clk;

    mesh_route_unit #(.COORD_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .cong(cong), .out_valid(out_valid), .out_port(out_port)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one head flit: drive on a falling edge, read one edge after registering
    task automatic route_case(input string req, input logic [1:0] m,
                              input logic [2:0] dx, input logic [2:0] dy,
                              input logic [3:0] cg, input logic [4:0] exp);
        @(negedge clk);
        in_valid = 1'b1; mode = m; cur_x = 3'd3; cur_y = 3'd3;
        dst_x = dx; dst_y = dy; cong = cg;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, out_port}, {1'b1, exp});
    endtask

    task automatic test_reset();
        rst_n = 1'b0; in_valid = 1'b0; mode = 2'd0;
        cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0; cong = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset", {out_valid, out_port}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_valid, out_port}, 6'b0);
    endtask

    task automatic test_hold();
        route_case("R2 setup", 2'd1, 3'd5, 3'd0, 4'b0001, S);
        dst_x = 3'd0; cong = 4'b0000;
        @(negedge clk);
        check("R2 valid drops, port held", {out_valid, out_port}, {1'b0, S});
    endtask

    task automatic test_local();
        route_case("R3 xy local", 2'd0, 3'd3, 3'd3, 4'b1111, L);
        route_case("R3 wf local", 2'd1, 3'd3, 3'd3, 4'b0000, L);
        route_case("R3 nl local", 2'd2, 3'd3, 3'd3, 4'b0101, L);
    endtask

    task automatic test_xy();
        route_case("R5 xy east first", 2'd0, 3'd5, 3'd6, 4'b0000, E);
        route_case("R5 xy west first", 2'd0, 3'd1, 3'd0, 4'b0000, W);
        route_case("R5 xy north after x", 2'd0, 3'd3, 3'd7, 4'b0000, N);
        route_case("R4 xy south after x", 2'd0, 3'd3, 3'd0, 4'b0000, S);
        route_case("R5 mode3 as xy", 2'd3, 3'd5, 3'd6, 4'b0000, E);
        route_case("R11 xy ignores congestion", 2'd0, 3'd5, 3'd6, 4'b1111, E);
        route_case("R11 xy ignores east flag", 2'd0, 3'd6, 3'd1, 4'b0001, E);
    endtask

    task automatic test_wf();
        route_case("R6 wf west despite congestion", 2'd1, 3'd1, 3'd6, 4'b0010, W);
        route_case("R7 wf free pick east", 2'd1, 3'd5, 3'd6, 4'b0000, E);
        route_case("R7 wf avoid congested east", 2'd1, 3'd5, 3'd6, 4'b0001, N);
        route_case("R10 wf all congested fallback", 2'd1, 3'd5, 3'd6, 4'b0101, E);
        route_case("R7 wf south when east busy", 2'd1, 3'd5, 3'd0, 4'b0001, S);
    endtask

    task automatic test_nl();
        route_case("R8 nl east before north", 2'd2, 3'd5, 3'd6, 4'b0001, E);
        route_case("R8 nl north last", 2'd2, 3'd3, 3'd6, 4'b0100, N);
        route_case("R8 nl west before north", 2'd2, 3'd1, 3'd6, 4'b0000, W);
        route_case("R9 nl avoid congested east", 2'd2, 3'd5, 3'd0, 4'b0001, S);
        route_case("R10 nl none congested priority", 2'd2, 3'd1, 3'd0, 4'b0000, W);
        route_case("R9 nl avoid congested west", 2'd2, 3'd1, 3'd0, 4'b0010, S);
    endtask

    initial begin
        test_reset();
        test_local();
        test_xy();
        test_wf();
        test_nl();
        test_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule